// File: doc/BRIEF.md
# Host Port DMA Byte Sequencer

This block is the host-facing half of a byte-wide parallel port. It lets an external DMA engine feed 24-bit words into a processor one byte at a time. The host programs a control register. That register selects a DMA mode, sets the transfer direction and holds two general-purpose flags. It also accepts a one-shot initialise command, which primes the transmit path.

While a DMA mode is selected, the host does not supply lane addresses. An internal lane counter places successive bytes into the high, middle and low positions of the word, in that order, and then starts over. The low byte completes the word. At that point the word is handed to the processor side, and an active-low request pin throttles the DMA engine until the processor has taken the word.

With DMA mode off, the host picks the byte lane itself on every write. A small processor-side control register holds interrupt enables and two flags. Its receive enable turns unread data into a level interrupt request.

Top module: `hostDmaSeq`

## Requirements
- R1: After reset, `hostReqN` is 1, `txEmpty` is 1, `procRxFull` is 0, `procIrq` is 0, `ctrlRdata` is 0, `procCtrlRdata` is 0 and `laneOut` is 1.
- R2: `ctrlRdata` reads back the host control register as {init[7], mode[6:5], flags[4:3], 0[2], txReq[1], rxReq[0]}. A write with bit 7 set reads as 1 in the cycle after the write and as 0 from the next cycle on.
- R3: A control write with bit 7 and bit 1 both set sets `txEmpty` to 1, clears `procRxFull` to 0 and loads the lane counter with 1 (high lane). It takes priority over a data write or a processor read in the same cycle.
- R4: While mode bits [6:5] are nonzero, accepted data writes go to the lane shown on `laneOut` and ignore `hostLane`. The counter then steps 1→2→3→1 (1 = high byte, 2 = middle, 3 = low).
- R5: An accepted write to lane 3 sets `procWord` to {lane 1 byte, lane 2 byte, written byte}. In the same cycle it sets `procRxFull` to 1 and clears `txEmpty` to 0. Writes to lanes 1 and 2 leave `procWord` unchanged.
- R6: A data write while `txEmpty` is 0 is ignored: `procWord` and `laneOut` do not change.
- R7: `procRdEn` while `procRxFull` is 1 clears `procRxFull` and sets `txEmpty` on the next edge. `txEmpty` and `procRxFull` are never equal.
- R8: `hostReqN` is 0 exactly when the mode bits are nonzero, bit 1 (txReq) is set and `txEmpty` is 1. Otherwise it is 1.
- R9: With mode bits 00, a data write goes to the lane given by `hostLane`, in any order, and the lane counter does not move. A write with `hostLane` = 0 is ignored.
- R10: `procCtrlRdata` reads back the 5-bit processor control register. Its bit 0 is the receive interrupt enable, and `procIrq` equals that bit ANDed with `procRxFull`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ctrlWrEn | input | 1 | Host control register write strobe |
| ctrlWdata | input | 8 | Host control register write value |
| ctrlRdata | output | 8 | Host control register read value |
| dataWrEn | input | 1 | Host data byte write strobe |
| dataByte | input | 8 | Host data byte |
| hostLane | input | 2 | Host-chosen byte lane when not in DMA mode |
| hostReqN | output | 1 | Active-low DMA request |
| txEmpty | output | 1 | Transmit register can accept a byte |
| laneOut | output | 2 | Current DMA lane counter value |
| procRdEn | input | 1 | Processor reads the assembled word |
| procWord | output | 24 | Assembled word for the processor |
| procRxFull | output | 1 | Unread word present on processor side |
| procCtrlWrEn | input | 1 | Processor control register write strobe |
| procCtrlWdata | input | 5 | Processor control register write value |
| procCtrlRdata | output | 5 | Processor control register read value |
| procIrq | output | 1 | Level receive interrupt request |

## Verification
The bench targets the following corner cases, each paired with the fault it would expose:
- Bytes written while the buffer is full. A design without the guard would overwrite the pending word or advance the lane, and the next word would be misaligned.
- An initialise in the middle of a word. The lane must restart at the high byte; a design that ignored it would place the next bytes one or two lanes off.
- Bytes sent with `hostLane` garbage during DMA, and written out of lane order with DMA off. These catch a lane source chosen from the wrong input.
- Leaving DMA mode. The request pin must go high even though the buffer is empty.

// File: rtl/hostDmaPkg.sv
package hostDmaPkg;
  localparam int BYTE_W  = 8;
  localparam int LANES   = 3;
  localparam int WORD_W  = BYTE_W * LANES;
  localparam int LANE_W  = $clog2(LANES + 1);
  localparam int PCTRL_W = 5;
  // host control register bit positions
  localparam int INIT_BIT = 7;
  localparam int MODE_HI  = 6;
  localparam int MODE_LO  = 5;
  localparam int FLAG_HI  = 4;
  localparam int FLAG_LO  = 3;
  localparam int TXRQ_BIT = 1;
  localparam int RXRQ_BIT = 0;
  localparam int RXIE_BIT = 0;

  typedef struct packed {
    logic [LANES-1:0] loadLane;  // bit i: store byte into lane i+1
  } strobe_t;
endpackage

// File: rtl/hostDmaCtrl.sv
module hostDmaCtrl
  import hostDmaPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               ctrlWrEn,
  input  logic [7:0]         ctrlWdata,
  output logic [7:0]         ctrlRdata,
  input  logic               dataWrEn,
  input  logic [LANE_W-1:0]  hostLane,
  input  logic               procRdEn,
  input  logic               procCtrlWrEn,
  input  logic [PCTRL_W-1:0] procCtrlWdata,
  output logic [PCTRL_W-1:0] procCtrlRdata,
  output logic               hostReqN,
  output logic               txEmpty,
  output logic               rxFull,
  output logic               procIrq,
  output logic [LANE_W-1:0]  laneOut,
  output strobe_t            strb
);
  logic [1:0] hostMode, hostFlags;
  logic txReqEn, rxReqEn, initPend;
  logic [LANE_W-1:0] laneCnt, effLane, nextLane;
  logic txEmptyQ, rxFullQ;
  logic [PCTRL_W-1:0] pCtrl;
  logic dmaOn, initWr, initTx, accept, lastLane, takeWord;

  assign dmaOn    = hostMode != 2'b00;
  assign initWr   = ctrlWrEn & ctrlWdata[INIT_BIT];
  assign initTx   = initWr & ctrlWdata[TXRQ_BIT];
  assign effLane  = dmaOn ? laneCnt : hostLane;
  assign accept   = dataWrEn & txEmptyQ & (effLane != '0) & ~initTx;
  assign lastLane = effLane == LANE_W'(LANES);
  assign takeWord = procRdEn & rxFullQ & ~initTx;
  assign nextLane = (laneCnt == LANE_W'(LANES)) ? LANE_W'(1) : laneCnt + LANE_W'(1);

  always_comb begin
    strb.loadLane = '0;
    for (int i = 0; i < LANES; i++)
      strb.loadLane[i] = accept && (effLane == LANE_W'(i + 1));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hostMode  <= '0;
      hostFlags <= '0;
      txReqEn   <= 1'b0;
      rxReqEn   <= 1'b0;
      initPend  <= 1'b0;
    end else begin
      initPend <= initWr;
      if (ctrlWrEn) begin
        hostMode  <= ctrlWdata[MODE_HI:MODE_LO];
        hostFlags <= ctrlWdata[FLAG_HI:FLAG_LO];
        txReqEn   <= ctrlWdata[TXRQ_BIT];
        rxReqEn   <= ctrlWdata[RXRQ_BIT];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txEmptyQ <= 1'b1;
      rxFullQ  <= 1'b0;
      laneCnt  <= LANE_W'(1);
    end else begin
      if (initTx) begin
        txEmptyQ <= 1'b1;
        rxFullQ  <= 1'b0;
      end else if (accept && lastLane) begin
        txEmptyQ <= 1'b0;
        rxFullQ  <= 1'b1;
      end else if (takeWord) begin
        txEmptyQ <= 1'b1;
        rxFullQ  <= 1'b0;
      end
      if (initTx)
        laneCnt <= LANE_W'(1);
      else if (accept && dmaOn)
        laneCnt <= nextLane;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             pCtrl <= '0;
    else if (procCtrlWrEn) pCtrl <= procCtrlWdata;
  end

  assign ctrlRdata     = {initPend, hostMode, hostFlags, 1'b0, txReqEn, rxReqEn};
  assign procCtrlRdata = pCtrl;
  assign hostReqN      = ~(dmaOn & txReqEn & txEmptyQ);
  assign txEmpty       = txEmptyQ;
  assign rxFull        = rxFullQ;
  assign procIrq       = pCtrl[RXIE_BIT] & rxFullQ;
  assign laneOut       = laneCnt;
endmodule

// File: rtl/hostDmaPath.sv
module hostDmaPath
  import hostDmaPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [BYTE_W-1:0] dataByte,
  input  strobe_t           strb,
  output logic [WORD_W-1:0] procWord
);
  logic [BYTE_W-1:0] laneByte [LANES-1];
  logic [WORD_W-1:0] assembled;

  for (genvar g = 0; g < LANES - 1; g++) begin : g_lane
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                laneByte[g] <= '0;
      else if (strb.loadLane[g]) laneByte[g] <= dataByte;
    end
  end

  always_comb begin
    assembled = '0;
    for (int i = 0; i < LANES - 1; i++)
      assembled[WORD_W-1-i*BYTE_W -: BYTE_W] = laneByte[i];
    assembled[BYTE_W-1:0] = dataByte;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                        procWord <= '0;
    else if (strb.loadLane[LANES-1]) procWord <= assembled;
  end
endmodule

// File: rtl/hostDmaSeq.sv
module hostDmaSeq
  import hostDmaPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               ctrlWrEn,
  input  logic [7:0]         ctrlWdata,
  output logic [7:0]         ctrlRdata,
  input  logic               dataWrEn,
  input  logic [BYTE_W-1:0]  dataByte,
  input  logic [LANE_W-1:0]  hostLane,
  output logic               hostReqN,
  output logic               txEmpty,
  output logic [LANE_W-1:0]  laneOut,
  input  logic               procRdEn,
  output logic [WORD_W-1:0]  procWord,
  output logic               procRxFull,
  input  logic               procCtrlWrEn,
  input  logic [PCTRL_W-1:0] procCtrlWdata,
  output logic [PCTRL_W-1:0] procCtrlRdata,
  output logic               procIrq
);
  strobe_t strb;

  hostDmaCtrl ctrl_i (
    .clk(clk), .rstN(rstN),
    .ctrlWrEn(ctrlWrEn), .ctrlWdata(ctrlWdata), .ctrlRdata(ctrlRdata),
    .dataWrEn(dataWrEn), .hostLane(hostLane), .procRdEn(procRdEn),
    .procCtrlWrEn(procCtrlWrEn), .procCtrlWdata(procCtrlWdata),
    .procCtrlRdata(procCtrlRdata), .hostReqN(hostReqN), .txEmpty(txEmpty),
    .rxFull(procRxFull), .procIrq(procIrq), .laneOut(laneOut), .strb(strb)
  );

  hostDmaPath path_i (
    .clk(clk), .rstN(rstN), .dataByte(dataByte), .strb(strb),
    .procWord(procWord)
  );
endmodule

// File: rtl/hostDmaSeqChk.sv
module hostDmaSeqChk
  import hostDmaPkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               ctrlWrEn,
  input logic [7:0]         ctrlWdata,
  input logic [7:0]         ctrlRdata,
  input logic               hostReqN,
  input logic               txEmpty,
  input logic [LANE_W-1:0]  laneOut,
  input logic [WORD_W-1:0]  procWord,
  input logic               procRxFull,
  input logic               procIrq
);
  AST_FLAGS_OPPOSITE: assert property (@(posedge clk) disable iff (!rstN)
    txEmpty != procRxFull); // R7
  AST_REQ_HELD_WHEN_FULL: assert property (@(posedge clk) disable iff (!rstN)
    !txEmpty |-> hostReqN); // R8
  AST_REQ_IDLE_NORMAL: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlRdata[MODE_HI:MODE_LO] == 2'b00) |-> hostReqN); // R8
  AST_INIT_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    ctrlRdata[INIT_BIT] |=> !ctrlRdata[INIT_BIT]); // R2
  AST_INIT_PRIMES: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWrEn && ctrlWdata[INIT_BIT] && ctrlWdata[TXRQ_BIT]) |=>
      (txEmpty && !procRxFull && laneOut == LANE_W'(1))); // R3
  AST_LANE_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    laneOut != '0 && laneOut <= LANE_W'(LANES)); // R4
  AST_WORD_HELD_WHILE_FULL: assert property (@(posedge clk) disable iff (!rstN)
    procRxFull |=> $stable(procWord)); // R6
  AST_IRQ_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rstN)
    procIrq |-> procRxFull); // R10
endmodule

bind hostDmaSeq hostDmaSeqChk chk_i (.*);

// File: tb/hostDmaSeq_tb.sv
module hostDmaSeq_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ctrlWrEn = 0, dataWrEn = 0, procRdEn = 0, procCtrlWrEn = 0;
  logic [7:0] ctrlWdata = 0, dataByte = 0;
  logic [1:0] hostLane = 0;
  logic [4:0] procCtrlWdata = 0;
  logic [7:0] ctrlRdata;
  logic hostReqN, txEmpty, procRxFull, procIrq;
  logic [1:0] laneOut;
  logic [23:0] procWord;
  logic [4:0] procCtrlRdata;

  int checks = 0, fails = 0, cycles = 0;
  bit done = 0;

  always #5 clk = ~clk;

  hostDmaSeq dut_i (.*);

  // behavioural reference state
  int mMode = 0, mFlags = 0, mTx = 0, mRx = 0, mInit = 0, mLane = 1;
  int mTxE = 1, mRxF = 0, mPc = 0;
  int mBytes [1:3] = '{0, 0, 0};
  int mWord = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      mMode = 0; mFlags = 0; mTx = 0; mRx = 0; mInit = 0; mLane = 1;
      mTxE = 1; mRxF = 0; mPc = 0; mWord = 0; mBytes = '{0, 0, 0};
    end else begin
      automatic bit dma = (mMode != 0);
      automatic bit prime = ctrlWrEn && ctrlWdata[7] && ctrlWdata[1];
      automatic int ln = dma ? mLane : int'(hostLane);
      mInit = (ctrlWrEn && ctrlWdata[7]) ? 1 : 0;
      if (ctrlWrEn) begin
        mMode = ctrlWdata[6:5]; mFlags = ctrlWdata[4:3];
        mTx = ctrlWdata[1]; mRx = ctrlWdata[0];
      end
      if (prime) begin
        mTxE = 1; mRxF = 0; mLane = 1;
      end else if (dataWrEn && mTxE == 1 && ln != 0) begin
        mBytes[ln] = dataByte;
        if (dma) mLane = (mLane == 3) ? 1 : mLane + 1;
        if (ln == 3) begin
          mWord = (mBytes[1] << 16) | (mBytes[2] << 8) | mBytes[3];
          mTxE = 0; mRxF = 1;
        end
      end else if (procRdEn && mRxF == 1) begin
        mRxF = 0; mTxE = 1;
      end
      if (procCtrlWrEn) mPc = procCtrlWdata;
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && !done) begin
      check("R2 ctrlRdata", ctrlRdata,
            (mInit << 7) | (mMode << 5) | (mFlags << 3) | (mTx << 1) | mRx);
      check("R4 laneOut", laneOut, mLane);
      check("R5 procWord", procWord, mWord);
      check("R5 txEmpty", txEmpty, mTxE);
      check("R7 procRxFull", procRxFull, mRxF);
      check("R8 hostReqN", hostReqN, (mMode != 0 && mTx == 1 && mTxE == 1) ? 0 : 1);
      check("R10 procCtrlRdata", procCtrlRdata, mPc);
      check("R10 procIrq", procIrq, mPc[0] & mRxF);
    end
  end

  task automatic tick();
    @(negedge clk); #1;
  endtask
  task automatic wrCtrl(logic [7:0] v);
    ctrlWrEn = 1; ctrlWdata = v; tick(); ctrlWrEn = 0;
  endtask
  task automatic wrByte(logic [7:0] b, logic [1:0] ln);
    dataWrEn = 1; dataByte = b; hostLane = ln; tick(); dataWrEn = 0;
  endtask
  task automatic rdWord();
    procRdEn = 1; tick(); procRdEn = 0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    rstN = 1;
    tick();
    check("R1 reset hostReqN", hostReqN, 1);
    check("R1 reset txEmpty", txEmpty, 1);
    check("R1 reset rxFull", procRxFull, 0);
    check("R1 reset ctrlRdata", ctrlRdata, 0);
    check("R1 reset laneOut", laneOut, 1);
    check("R1 reset procIrq", procIrq, 0);

    procCtrlWrEn = 1; procCtrlWdata = 5'b10101; tick(); procCtrlWrEn = 0;

    wrCtrl(8'hA2);  // init, mode 01, txReq
    check("R2 init reads 1", ctrlRdata[7], 1);
    tick();
    check("R2 init cleared", ctrlRdata[7], 0);
    check("R3 lane primed", laneOut, 1);
    check("R8 request active", hostReqN, 0);

    wrByte(8'h12, 2'd0); wrByte(8'h34, 2'd3); wrByte(8'h56, 2'd1);
    check("R5 word", procWord, 24'h123456);
    check("R8 request held off", hostReqN, 1);
    check("R10 irq raised", procIrq, 1);

    wrByte(8'hEE, 2'd1); wrByte(8'hDD, 2'd2);
    check("R6 word kept", procWord, 24'h123456);
    check("R6 lane kept", laneOut, 1);

    rdWord();
    check("R7 txEmpty back", txEmpty, 1);
    check("R10 irq dropped", procIrq, 0);

    wrByte(8'hA1, 2'd2); wrByte(8'hB2, 2'd2);
    check("R4 lane at low", laneOut, 3);
    wrCtrl(8'hC2);  // init mid-word, mode 10
    check("R3 lane restart", laneOut, 1);
    wrByte(8'h9A, 2'd0); wrByte(8'hBC, 2'd0); wrByte(8'hDE, 2'd0);
    check("R4 wrap word", procWord, 24'h9ABCDE);
    check("R4 lane wrapped", laneOut, 1);
    rdWord();

    wrCtrl(8'h62);  // mode 11
    for (int k = 0; k < 4; k++) begin
      wrByte(8'(k * 3 + 1), 2'd0); wrByte(8'(k * 3 + 2), 2'd0); wrByte(8'(k * 3 + 3), 2'd0);
      check("R5 stream word", procWord, (k * 3 + 1) << 16 | (k * 3 + 2) << 8 | (k * 3 + 3));
      rdWord();
    end

    wrCtrl(8'h18);  // normal mode, flags 11
    check("R8 request off in normal", hostReqN, 1);
    check("R2 flags", ctrlRdata, 8'h18);
    wrByte(8'h77, 2'd0);
    check("R9 lane 0 ignored", procRxFull, 0);
    wrByte(8'h33, 2'd2); wrByte(8'h11, 2'd1);
    check("R9 lane counter idle", laneOut, 1);
    wrByte(8'h55, 2'd3);
    check("R9 host lanes", procWord, 24'h113355);
    rdWord();

    procCtrlWrEn = 1; procCtrlWdata = 5'b11110; tick(); procCtrlWrEn = 0;
    wrByte(8'h01, 2'd3);
    check("R10 irq masked", procIrq, 0);
    tick(); tick();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule